// File: doc/BRIEF.md
# Pipelined Carry-Bypass Adder

This block adds two WIDTH-bit operands and a carry-in. The operand width is split into 4-bit groups. Each group derives per-bit propagate and generate terms and ripples a carry across its four positions. A bypass multiplexer hands the incoming carry straight to the group's carry-out whenever all four propagate terms are set.

Every group is its own pipeline stage, and a register holds the carry passed from one group to the next. Operand slices are skewed on entry: group k receives its slice k cycles late. Sum slices are de-skewed on exit, so every result bit leaves in the same cycle. The stage logic does not depend on WIDTH, so the clock period is the same at any width. Latency is one cycle per group, and a new operand pair can be taken every cycle. WIDTH must be a positive multiple of 4, and elaboration stops otherwise.

Top module: `pipe_bypass_adder`

## Requirements
- R1: When out_valid is high, {out_cout, out_sum} equals the (WIDTH+1)-bit value in_a + in_b + in_cin that was presented with the matching in_valid.
- R2: A sample taken with in_valid high at a rising edge shows up with out_valid high exactly WIDTH/4 rising edges later, one cycle per 4-bit group.
- R3: Operands with in_valid high can be presented on every consecutive cycle. Each one yields exactly one result, and results come out in input order.
- R4: out_valid is low in any cycle whose matching input cycle had in_valid low. Bubbles pass through unchanged.
- R5: While rst is high at a rising edge, out_valid, out_sum and out_cout are zero after that edge. Operations already in flight are discarded.
- R6: If every bit of a 4-bit group propagates (in_a XOR in_b is 1111 in that slice), the group passes its incoming carry on unchanged. For example, all-ones plus zero with in_cin = 1 gives sum 0 and out_cout = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operands in this cycle |
| in_a | input | WIDTH | First addend |
| in_b | input | WIDTH | Second addend |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Qualifies out_sum and out_cout |
| out_sum | output | WIDTH | Low WIDTH bits of the sum |
| out_cout | output | 1 | Carry out of the top bit |

## Verification
The bench runs a two-group configuration through every operand pair and both carry-in values, back to back. This covers every carry that crosses the group boundary, and every case where a group's bypass multiplexer fires. A bypass that selected the wrong source would break the all-propagate vectors. A misaligned skew or de-skew chain would mix slices from neighbouring operations and corrupt the sums during back-to-back traffic. A separate phase inserts bubbles and a mid-flight reset. A valid chain one stage too short or too long would show up there as early, late or phantom results, and a reset that missed some stage would let a dropped operation escape.

// File: rtl/cba_pkg.sv
package cba_pkg;
    localparam int GRP_W = 4;

    typedef logic [GRP_W-1:0] nib_t;

    typedef struct packed {
        nib_t prop;
        nib_t gen;
    } pg_t;

    typedef struct packed {
        logic cout;
        nib_t sum;
    } grp_res_t;

    function automatic pg_t make_pg(input nib_t a, input nib_t b);
        pg_t r;
        r.prop = a ^ b;
        r.gen  = a & b;
        return r;
    endfunction
endpackage

// File: rtl/cba_group.sv
module cba_group
    import cba_pkg::*;
(
    input  nib_t     a,
    input  nib_t     b,
    input  logic     cin,
    output grp_res_t res
);
    pg_t              pg;
    logic [GRP_W:0]   chain;
    logic             skip;

    always_comb begin
        pg       = make_pg(a, b);
        chain[0] = cin;
        for (int i = 0; i < GRP_W; i++) begin
            chain[i+1] = pg.gen[i] | (pg.prop[i] & chain[i]);
        end
        skip     = &pg.prop;
        res.sum  = pg.prop ^ chain[GRP_W-1:0];
        res.cout = skip ? cin : chain[GRP_W];
    end
endmodule

// File: rtl/cba_delay.sv
module cba_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH < 1) begin : g_bad_depth
            $fatal(1, "cba_delay needs DEPTH of at least 1");
        end
    endgenerate

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pipe_bypass_adder.sv
module pipe_bypass_adder
    import cba_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);
    localparam int NGRP = WIDTH / GRP_W;

    generate
        if ((WIDTH % GRP_W) != 0 || WIDTH < GRP_W) begin : g_bad_width
            $fatal(1, "WIDTH must be a positive multiple of 4");
        end
    endgenerate

    grp_res_t res     [NGRP];
    logic     carry_q [NGRP];

    // inter-group carry registers; the last one is the final carry-out
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NGRP; k++) carry_q[k] <= 1'b0;
        end else begin
            for (int k = 0; k < NGRP; k++) carry_q[k] <= res[k].cout;
        end
    end

    assign out_cout = carry_q[NGRP-1];

    genvar k;
    generate
        for (k = 0; k < NGRP; k++) begin : g_grp
            nib_t op_a;
            nib_t op_b;
            logic grp_cin;

            if (k == 0) begin : g_first
                assign op_a    = in_a[GRP_W-1:0];
                assign op_b    = in_b[GRP_W-1:0];
                assign grp_cin = in_cin;
            end else begin : g_later
                logic [2*GRP_W-1:0] skewed;
                cba_delay #(.W(2*GRP_W), .DEPTH(k)) u_skew (
                    .clk (clk),
                    .rst (rst),
                    .d   ({in_a[k*GRP_W +: GRP_W], in_b[k*GRP_W +: GRP_W]}),
                    .q   (skewed)
                );
                assign op_a    = skewed[2*GRP_W-1:GRP_W];
                assign op_b    = skewed[GRP_W-1:0];
                assign grp_cin = carry_q[k-1];
            end

            cba_group u_grp (
                .a   (op_a),
                .b   (op_b),
                .cin (grp_cin),
                .res (res[k])
            );

            cba_delay #(.W(GRP_W), .DEPTH(NGRP-k)) u_deskew (
                .clk (clk),
                .rst (rst),
                .d   (res[k].sum),
                .q   (out_sum[k*GRP_W +: GRP_W])
            );
        end
    endgenerate

    cba_delay #(.W(1), .DEPTH(NGRP)) u_vpipe (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             in_cin,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_cout
);
    localparam int NGRP = WIDTH / 4;

    logic             vsh [NGRP];
    logic [WIDTH:0]   ssh [NGRP];
    logic             rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            for (int i = 0; i < NGRP; i++) begin
                vsh[i] <= 1'b0;
                ssh[i] <= '0;
            end
        end else begin
            vsh[0] <= in_valid;
            ssh[0] <= {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_cin};
            for (int i = 1; i < NGRP; i++) begin
                vsh[i] <= vsh[i-1];
                ssh[i] <= ssh[i-1];
            end
        end
    end

    a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({out_cout, out_sum} == ssh[NGRP-1]));

    a_r2_result_on_time: assert property (@(posedge clk) disable iff (rst)
        vsh[NGRP-1] |-> out_valid);

    a_r4_no_phantom: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> vsh[NGRP-1]);

    // R5: outputs are zero in the cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d == 1'b1) begin
            a_r5_reset_clears: assert (!out_valid && out_sum == '0 && !out_cout);
        end
    end
endmodule

bind pipe_bypass_adder pba_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_pipe_bypass_adder.sv
module sim_pipe_bypass_adder;
    localparam int W = 8;
    localparam int G = W / 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_cin = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int sent = 0;
    int seen = 0;

    typedef struct {
        int         cyc;
        logic [W:0] exp;
        bit         bypass;
    } ent_t;
    ent_t q[$];

    always #10 clk = ~clk;

    pipe_bypass_adder #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_outputs();
        bit exp_v;
        exp_v = (q.size() > 0) && (q[0].cyc + G == cyc);
        if (exp_v) check("R2 result latency", {8'h0, out_valid}, 9'h1);
        else       check("R4 bubble stays invalid", {8'h0, out_valid}, 9'h0);
        if (exp_v) begin
            if (q[0].bypass) check("R6 group bypass sum", {out_cout, out_sum}, q[0].exp);
            else             check("R1 sum", {out_cout, out_sum}, q[0].exp);
            void'(q.pop_front());
            seen++;
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        ent_t e;
        @(negedge clk);
        cyc++;
        check_outputs();
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_cin   = c;
        if (v) begin
            e.cyc    = cyc;
            e.exp    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
            e.bypass = ((a ^ b) & 8'h0F) == 8'h0F || ((a ^ b) & 8'hF0) == 8'hF0;
            q.push_back(e);
            sent++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cyc += 3;
        check("R5 reset clears outputs", {out_cout, out_sum}, 9'h0);
        check("R5 reset clears valid", {8'h0, out_valid}, 9'h0);
        rst = 1'b0;

        // specific corner vectors
        step(1'b1, 8'hFF, 8'h00, 1'b1);   // R6: full propagate, carry passes both groups
        step(1'b1, 8'hFF, 8'h01, 1'b0);   // all-ones plus one
        step(1'b1, 8'hFF, 8'hFF, 1'b1);
        step(1'b1, 8'h0F, 8'h00, 1'b1);   // R6: low group bypass into upper group
        step(1'b0, 8'h00, 8'h00, 1'b0);

        // exhaustive back-to-back sweep (R1, R3, R6)
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++)
                    step(1'b1, a[7:0], b[7:0], c[0]);
        for (int i = 0; i < G + 2; i++) step(1'b0, 8'h00, 8'h00, 1'b0);
        check("R3 one result per input", 9'(seen), 9'(sent));

        // bubbles (R4)
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            step((i % 3) != 0, r[7:0], r[15:8], r[16]);
        end
        for (int i = 0; i < G + 2; i++) step(1'b0, 8'h00, 8'h00, 1'b0);

        // reset with work in flight (R5)
        step(1'b1, 8'hA5, 8'h5A, 1'b1);
        @(negedge clk);
        cyc++;
        rst      = 1'b1;
        in_valid = 1'b0;
        q.delete();
        step(1'b0, 8'h00, 8'h00, 1'b0);
        check("R5 in-flight result dropped", {out_cout, out_sum}, 9'h0);
        rst = 1'b0;
        for (int i = 0; i < G + 2; i++) step(1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b1, 8'h80, 8'h80, 1'b0);
        for (int i = 0; i < G + 1; i++) step(1'b0, 8'h00, 8'h00, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule